// File: doc/BRIEF.md
# SD card clock divider

This block makes the SD card bus clock from the host reference clock. The reference is 24 MHz in the intended system. Software programs it through a small register write port. A 16-bit control word carries three things: a one-hot divide code, a card-clock enable and a bypass request. A one-bit mode register decides whether the bypass request is honoured. A separate gate-wait register must also be enabled before the card clock may run.

The divided path is a power-of-two ladder. It runs from divide-by-4 up to divide-by-1024, and 24 MHz divided by 512 gives the slowest standard rate of 46 875 Hz. The bypass path passes the reference clock through a gate that changes only while the reference is low, which gives a 24 MHz card clock. Settings change only at period boundaries, so the card clock never shows a runt pulse.

Alongside the clock, the block issues a one-cycle strobe in the reference domain for every rising card-clock edge. The command and data shifters use this strobe as their clock enable.

Top module: `sdclk_div`

## Requirements
- R1: After reset all three registers read as zero in effect, so the card clock is low and the shift strobe stays low.
- R2: With mode = 1, a control code whose highest set bit among bits [7:0] is bit k divides by 2^(k+3). Code 0x40 gives divide-by-512. When several code bits are set, the highest one wins.
- R3: With mode = 1 and control bits [7:0] all zero, the divide ratio is 4.
- R4: When control bit 15 is 1 and mode is 0, the card clock equals the reference clock, with one strobe per reference cycle. When mode is 1, bit 15 has no effect. When bit 15 is 0, mode 0 also selects the divided path.
- R5: The card clock runs only while control bit 8 and gate-wait register bit 8 are both 1.
- R6: When the clock is disabled during a high phase, that phase completes at full length. The card clock then stays low with no strobe.
- R7: A new divide setting written while the clock runs takes effect at the next rising card edge. The high and low phases already under way keep the old length.
- R8: The shift strobe is high for exactly one reference cycle. It starts at the reference edge where the card clock rises.
- R9: On the divided path, the high and low phases each last half the divide ratio, counted in reference cycles.
- R10: Write select 0 loads the control word, select 1 loads the mode bit from data bit 0, and select 2 loads the gate-wait bit from data bit 8. Select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select for the write |
| wrData | input | 16 | Write data |
| cardClk | output | 1 | Gated card clock |
| shiftStb | output | 1 | One-cycle enable at each rising card-clock edge |

## Verification
Every one-hot code position is run, along with an empty code, a code with two bits set, and all four combinations of the bypass bit and the mode bit. Together these show that the divide ladder ordering and the highest-bit priority are correct, and that bypass needs both conditions. Each setting is measured by the strobe-to-strobe spacing and by the high-phase length. This separates a wrong ratio from a wrong duty cycle, and a strobe that is misplaced from one that is too wide. Directed sequences then change the divisor and clear the enable in the middle of a high phase, which exposes any phase that is cut short.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // write-port register selects
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_WAIT = 2'd2;

  // control-word fields the decode depends on
  localparam int EN_BIT  = 8;
  localparam int BYP_BIT = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture requested settings
    logic cntClear;  // restart the phase counter
    logic cntInc;    // advance the phase counter
    logic toggle;    // flip the divided output level
  } dpCmd_t;

endpackage

// File: rtl/sdclk_ctl.sv
module sdclk_ctl
  import sdclk_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LOG_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [15:0]      wrData,
  input  logic             dpHigh,
  input  logic             dpTerm,
  input  logic             dpBypass,
  output dpCmd_t           cmd,
  output logic             reqBypass,
  output logic             reqLive,
  output logic [LOG_W-1:0] reqLog
);

  localparam int MIN_LOG = 1;

  logic [15:0] ctrlReg;
  logic        modeReg;
  logic        waitReg;
  logic        run;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modeReg <= 1'b0;
      waitReg <= 1'b0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_CTRL: ctrlReg <= wrData;
        SEL_MODE: modeReg <= wrData[0];
        SEL_WAIT: waitReg <= wrData[EN_BIT];
        default:  ;
      endcase
    end
  end

  assign run       = ctrlReg[EN_BIT] & waitReg;
  assign reqBypass = ctrlReg[BYP_BIT] & ~modeReg;
  assign reqLive   = reqBypass & run;

  // highest set code bit selects the half-period exponent
  always_comb begin
    reqLog = LOG_W'(MIN_LOG);
    for (int k = 0; k < CODE_W; k++) begin
      if (ctrlReg[k]) reqLog = LOG_W'(k + 2);
    end
  end

  always_comb begin
    cmd = '0;
    if (dpBypass) begin
      cmd.loadCfg  = 1'b1;
      cmd.cntClear = 1'b1;
    end else if (dpHigh) begin
      if (dpTerm) begin
        cmd.toggle   = 1'b1;
        cmd.cntClear = 1'b1;
      end else begin
        cmd.cntInc = 1'b1;
      end
    end else if (!run) begin
      cmd.loadCfg  = 1'b1;
      cmd.cntClear = 1'b1;
    end else if (dpTerm) begin
      cmd.loadCfg  = 1'b1;
      cmd.cntClear = 1'b1;
      cmd.toggle   = !reqBypass;
    end else begin
      cmd.cntInc = 1'b1;
    end
  end

  AST_STOPPED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !dpHigh && !dpBypass) |=> !dpHigh); // R6

  AST_NO_RISE_WITHOUT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !dpHigh) |=> !$rose(dpHigh)); // R5

endmodule

// File: rtl/sdclk_dp.sv
module sdclk_dp
  import sdclk_pkg::*;
#(
  parameter int LOG_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             reqBypass,
  input  logic             reqLive,
  input  logic [LOG_W-1:0] reqLog,
  output logic             dpHigh,
  output logic             dpTerm,
  output logic             dpBypass,
  output logic             cardClk,
  output logic             shiftStb
);

  localparam int MIN_LOG = 1;

  logic [CNT_W-1:0] cnt;
  logic [LOG_W-1:0] activeLog;
  logic             activeBypass;
  logic             bypassLive;
  logic             divHigh;
  logic             gateLow;
  logic             strobeByp;
  logic [CNT_W:0]   halfLen;

  assign halfLen = (CNT_W + 1)'(1) << activeLog;
  assign dpTerm  = ({1'b0, cnt} == halfLen - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      activeLog    <= LOG_W'(MIN_LOG);
      activeBypass <= 1'b0;
      bypassLive   <= 1'b0;
      divHigh      <= 1'b0;
    end else begin
      if (cmd.cntClear)    cnt <= '0;
      else if (cmd.cntInc) cnt <= cnt + 1'b1;
      if (cmd.loadCfg) begin
        activeLog    <= reqLog;
        activeBypass <= reqBypass;
        bypassLive   <= reqLive;
      end
      if (cmd.toggle) divHigh <= ~divHigh;
    end
  end

  // bypass gate moves only while the reference is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateLow <= 1'b0;
    else       gateLow <= bypassLive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeByp <= 1'b0;
    else       strobeByp <= gateLow;
  end

  assign cardClk  = divHigh | (clk & gateLow);
  assign shiftStb = (divHigh && cnt == '0) | strobeByp;
  assign dpHigh   = divHigh;
  assign dpBypass = activeBypass;

  AST_CFG_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (divHigh && $past(divHigh)) |-> $stable(activeLog)); // R7

  AST_BYPASS_NO_DIV: assert property (@(posedge clk) disable iff (!rstN)
    activeBypass |-> !divHigh); // R4

  AST_STB_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divHigh) |-> shiftStb); // R8

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStb && !activeBypass && !strobeByp) |=> !shiftStb); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, cnt} < halfLen)); // R9

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  output logic        cardClk,
  output logic        shiftStb
);

  localparam int MAX_LOG = CODE_W + 1;
  localparam int CNT_W   = MAX_LOG;
  localparam int LOG_W   = $clog2(MAX_LOG + 1);

  dpCmd_t           cmd;
  logic             dpHigh;
  logic             dpTerm;
  logic             dpBypass;
  logic             reqBypass;
  logic             reqLive;
  logic [LOG_W-1:0] reqLog;

  sdclk_ctl #(.CODE_W(CODE_W), .LOG_W(LOG_W)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dpHigh(dpHigh), .dpTerm(dpTerm), .dpBypass(dpBypass), .cmd(cmd),
    .reqBypass(reqBypass), .reqLive(reqLive), .reqLog(reqLog)
  );

  sdclk_dp #(.LOG_W(LOG_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqBypass(reqBypass),
    .reqLive(reqLive), .reqLog(reqLog), .dpHigh(dpHigh), .dpTerm(dpTerm),
    .dpBypass(dpBypass), .cardClk(cardClk), .shiftStb(shiftStb)
  );

endmodule

// File: tb/sdclk_div_tb.sv
module sdclk_div_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        cardClk;
  logic        shiftStb;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  localparam int WD_LIMIT = 150000;

  sdclk_div dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cardClk(cardClk), .shiftStb(shiftStb)
  );

  always #10 clk = ~clk;

  localparam int VEC_N = 14;
  localparam logic [15:0] V_CODE [VEC_N] = '{
    16'h0001, 16'h0002, 16'h0004, 16'h0008, 16'h0010, 16'h0020, 16'h0040,
    16'h0080, 16'h0000, 16'h0024, 16'h8000, 16'h8000, 16'h0002, 16'h8010};
  localparam logic V_MODE [VEC_N] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int V_DIV [VEC_N] = '{
    8, 16, 32, 64, 128, 256, 512, 1024, 4, 256, 1, 4, 16, 1};
  // requirement per row: 0..7 R2 ladder, 8 R3 empty code, 9 R2 priority,
  // 10..13 R4 bypass/mode combinations
  localparam int V_REQ [VEC_N] = '{2, 2, 2, 2, 2, 2, 2, 2, 3, 2, 4, 4, 4, 4};

  function automatic string reqName(input int r);
    case (r)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      failCnt++;
      $display("FAIL watchdog (all requirements): cycles actual=%0d expected=below %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // every sample point is 5 ns after a rising reference edge
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic waitStb(output bit found);
    found = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      tick();
      if (shiftStb) begin found = 1'b1; break; end
    end
  endtask

  // strobe-to-strobe spacing and high samples, between strobes 2 and 3
  task automatic measure(output int per, output int hi, output bit riseOk);
    int n = 0;
    int t = 0;
    int t2 = 0;
    per = -1; hi = 0; riseOk = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      tick();
      t++;
      if (shiftStb) begin
        n++;
        if (cardClk !== 1'b1) riseOk = 1'b0;
        if (n == 2) t2 = t;
        if (n == 3) begin per = t - t2; break; end
      end
      if (n == 2 && cardClk) hi++;
    end
  endtask

  initial begin
    int per, hi, quiet, len;
    bit rok, found;

    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;

    // R1: reset state
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (cardClk || shiftStb) quiet++;
    end
    check(quiet == 0, "R1", "active samples after reset", quiet, 0);

    // R5: card enable alone does not start the clock
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0101);
    quiet = 0;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (cardClk || shiftStb) quiet++;
    end
    check(quiet == 0, "R5", "active samples without gate-wait", quiet, 0);
    wr(2'd2, 16'h0100);
    measure(per, hi, rok);
    check(per == 8, "R5", "period once both enables set", per, 8);

    // R10: select 3 is ignored
    wr(2'd3, 16'h0000);
    measure(per, hi, rok);
    check(per == 8, "R10", "period after select-3 write", per, 8);

    // vector table: ratio (R2/R3/R4), duty (R9), strobe at rise (R8)
    for (int v = 0; v < VEC_N; v++) begin
      int expHi;
      wr(2'd1, {15'd0, V_MODE[v]});
      wr(2'd0, V_CODE[v] | 16'h0100);
      measure(per, hi, rok);
      expHi = (V_DIV[v] == 1) ? 1 : V_DIV[v] / 2;
      check(per == V_DIV[v], reqName(V_REQ[v]), "strobe period", per, V_DIV[v]);
      check(hi == expHi, "R9", "high samples per period", hi, expHi);
      check(rok, "R8", "card clock high at strobe", rok, 1);
    end

    // R6: disable in the middle of a high phase at divide-by-64
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0108);
    measure(per, hi, rok);
    waitStb(found);
    len = 1;
    wr(2'd0, 16'h0008);
    if (cardClk) len++;
    for (int i = 0; i < 200 && cardClk; i++) begin
      tick();
      if (cardClk) len++;
    end
    check(len == 32 && found, "R6", "high samples after disable", len, 32);
    quiet = 0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (cardClk || shiftStb) quiet++;
    end
    check(quiet == 0, "R6", "active samples after stop", quiet, 0);

    // R7: change /1024 to /8 during a high phase
    wr(2'd0, 16'h0180);
    waitStb(found);
    len = 1;
    wr(2'd0, 16'h0101);
    if (cardClk) len++;
    for (int i = 0; i < 2000 && cardClk; i++) begin
      tick();
      if (cardClk) len++;
    end
    check(len == 512, "R7", "high phase in progress", len, 512);
    len = 1;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (shiftStb) break;
      len++;
    end
    check(len == 512, "R7", "low phase in progress", len, 512);
    len = 1;
    for (int i = 0; i < 2000; i++) begin
      tick();
      if (!cardClk) break;
      len++;
    end
    check(len == 4, "R7", "first high phase at new ratio", len, 4);

    // R4/R6: stop the bypass clock
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h8100);
    measure(per, hi, rok);
    check(per == 1, "R4", "bypass strobe period", per, 1);
    wr(2'd0, 16'h8000);
    repeat (3) tick();
    quiet = 0;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (cardClk || shiftStb) quiet++;
    end
    check(quiet == 0, "R6", "bypass active samples after stop", quiet, 0);

    summary();
  end

endmodule